// File: doc/BRIEF.md
# Row/Column Multiplexed Address Bus Front End

This block is the parallel programming-port front end of a byte-wide flash array. An external programmer presents a 19-bit array address over an 11-bit multiplexed address input, in two halves, using a single row/column select strobe. On the falling edge of that strobe the block takes the low part of the address from all eleven inputs. On the rising edge it takes the high part from the lowest eight inputs. The assembled address is held steady for the command controller between strobe edges.

The external strobes arrive without a clock: write-enable, output-enable, row/column select and the active-low interface reset. The block brings each of them, together with the address and data inputs, into the system clock domain through a two-stage synchroniser, and detects edges there. Each rising edge of write-enable becomes a one-cycle write pulse, with the byte sampled from the data bus at that edge. Each falling edge of output-enable while write-enable is inactive becomes a one-cycle read pulse. While a read is enabled, the block drives the byte supplied by the controller onto the bidirectional bus. It also reports a ready/busy level derived from the controller's busy flag.

Top module: `rcmux_bus_front`

## Requirements
- R1: A falling edge of the row/column select loads address bits 10..0 (`arr_addr_o[10:0]`) from `maddr_i[10:0]` and leaves bits 18..11 unchanged.
- R2: A rising edge of the row/column select loads address bits 18..11 (`arr_addr_o[18:11]`) from `maddr_i[7:0]`, ignores `maddr_i[10:8]` and leaves bits 10..0 unchanged.
- R3: Every rising edge of `we_n_i` produces exactly one `wr_pulse_o` lasting one clock. In the same cycle, `wr_data_o` carries the byte present on `dq_io` at that edge.
- R4: Every falling edge of `oe_n_i` while `we_n_i` is high produces exactly one `rd_pulse_o` lasting one clock. A falling edge of `oe_n_i` while `we_n_i` is low produces none.
- R5: While `oe_n_i` is low and `we_n_i` is high, `dq_io` carries `rd_byte_i`. In every other case the block leaves `dq_io` undriven, so the external driver's byte is what gets captured.
- R6: `rdy_o` is low in the clock after `busy_i` is high and high in the clock after `busy_i` is low.
- R7: While `ifc_rst_n_i` is low, the address clears to zero and neither `wr_pulse_o` nor `rd_pulse_o` is raised, whatever the strobes do.
- R8: After the system reset `rst_n`, the address is zero, both pulses are low and `rdy_o` is high.
- R9: A change on `maddr_i` with no select edge leaves `arr_addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| ifc_rst_n_i | input | 1 | Active-low interface reset, asynchronous to clk |
| maddr_i | input | 11 | Multiplexed address inputs |
| rcsel_i | input | 1 | Row/column select strobe |
| we_n_i | input | 1 | Active-low write enable |
| oe_n_i | input | 1 | Active-low output enable |
| dq_io | inout | 8 | Bidirectional data bus |
| rd_byte_i | input | 8 | Byte from the controller to be driven on reads |
| busy_i | input | 1 | Controller busy flag (program or erase running) |
| arr_addr_o | output | 19 | Assembled array address |
| wr_pulse_o | output | 1 | One-cycle bus-write pulse |
| wr_data_o | output | 8 | Byte captured on the bus write |
| rd_pulse_o | output | 1 | One-cycle bus-read pulse |
| rdy_o | output | 1 | Ready (high) / busy (low) |

## Verification
The bench builds the block with its default parameters: an 11-bit row part, an 8-bit column part, byte data and two synchroniser stages. With these values the full 19-bit address space can be reached, including all-ones rows and columns. Column codes that also have bits 10..8 set expose any leak of the unused upper inputs into the high address half. The two-stage depth fixes a short, known latency, so strobes held for a few clocks are enough to check edge counting, bus release and interface reset against a queue of expected transactions.

// File: rtl/rcmux_pkg.sv
package rcmux_pkg;
    parameter int unsigned RCM_ROW_W   = 11;
    parameter int unsigned RCM_COL_W   = 8;
    parameter int unsigned RCM_DATA_W  = 8;
    parameter int unsigned RCM_SYNC_N  = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_kind_e;
endpackage

// File: rtl/rcmux_sync.sv
module rcmux_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[g] <= {W{RST_VAL}};
                end else begin
                    if (g == 0) stg_q[g] <= async_i;
                    else        stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/rcmux_edge.sv
module rcmux_edge
    import rcmux_pkg::*;
#(
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    output edge_kind_e edge_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        if (lvl_i && !prev_q)      edge_o = EDGE_RISE;
        else if (!lvl_i && prev_q) edge_o = EDGE_FALL;
        else                       edge_o = EDGE_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_VAL;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/rcmux_addr_latch.sv
module rcmux_addr_latch #(
    parameter int unsigned ROW_W = 11,
    parameter int unsigned COL_W = 8,
    localparam int unsigned ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              row_cap_i,
    input  logic              col_cap_i,
    input  logic [ROW_W-1:0]  mux_i,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } addr_st_t;

    addr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (row_cap_i) st_d.row = mux_i;
            if (col_cap_i) st_d.col = mux_i[COL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q;
endmodule

// File: rtl/rcmux_bus_front.sv
module rcmux_bus_front
    import rcmux_pkg::*;
#(
    parameter int unsigned ROW_W   = RCM_ROW_W,
    parameter int unsigned COL_W   = RCM_COL_W,
    parameter int unsigned DATA_W  = RCM_DATA_W,
    parameter int unsigned SYNC_N  = RCM_SYNC_N,
    localparam int unsigned ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ifc_rst_n_i,
    input  logic [ROW_W-1:0]  maddr_i,
    input  logic              rcsel_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    inout  wire  [DATA_W-1:0] dq_io,
    input  logic [DATA_W-1:0] rd_byte_i,
    input  logic              busy_i,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic              wr_pulse_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_pulse_o,
    output logic              rdy_o
);
    localparam int unsigned STB_W = 4;

    // synchronised strobes: {ifc_rst_n, oe_n, we_n, rcsel}
    logic [STB_W-1:0]  stb_s;
    logic [ROW_W-1:0]  maddr_s;
    logic [DATA_W-1:0] dq_s;

    rcmux_sync #(.W(STB_W), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_stb_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({ifc_rst_n_i, oe_n_i, we_n_i, rcsel_i}),
        .sync_o(stb_s)
    );

    rcmux_sync #(.W(ROW_W), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_addr_sync (
        .clk(clk), .rst_n(rst_n), .async_i(maddr_i), .sync_o(maddr_s)
    );

    rcmux_sync #(.W(DATA_W), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_data_sync (
        .clk(clk), .rst_n(rst_n), .async_i(dq_io), .sync_o(dq_s)
    );

    logic rc_s, we_n_s, oe_n_s, ifc_clr;
    assign rc_s    = stb_s[0];
    assign we_n_s  = stb_s[1];
    assign oe_n_s  = stb_s[2];
    assign ifc_clr = !stb_s[3];

    edge_kind_e rc_edge, we_edge, oe_edge;

    rcmux_edge #(.IDLE_VAL(1'b1)) u_rc_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(rc_s), .edge_o(rc_edge)
    );
    rcmux_edge #(.IDLE_VAL(1'b1)) u_we_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(we_n_s), .edge_o(we_edge)
    );
    rcmux_edge #(.IDLE_VAL(1'b1)) u_oe_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(oe_n_s), .edge_o(oe_edge)
    );

    logic row_cap, col_cap;
    assign row_cap = (rc_edge == EDGE_FALL);
    assign col_cap = (rc_edge == EDGE_RISE);

    rcmux_addr_latch #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr_i(ifc_clr),
        .row_cap_i(row_cap), .col_cap_i(col_cap),
        .mux_i(maddr_s), .addr_o(arr_addr_o)
    );

    typedef struct packed {
        logic              wr_pulse;
        logic              rd_pulse;
        logic [DATA_W-1:0] wr_data;
        logic              drv_en;
        logic              busy;
    } bus_st_t;

    bus_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.wr_pulse = 1'b0;
        st_d.rd_pulse = 1'b0;
        st_d.busy     = busy_i;
        st_d.drv_en   = !oe_n_s && we_n_s;
        if (!ifc_clr) begin
            if (we_edge == EDGE_RISE) begin
                st_d.wr_pulse = 1'b1;
                st_d.wr_data  = dq_s;
            end
            if (oe_edge == EDGE_FALL && we_n_s) begin
                st_d.rd_pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_io      = st_q.drv_en ? rd_byte_i : {DATA_W{1'bz}};
    assign wr_pulse_o = st_q.wr_pulse;
    assign rd_pulse_o = st_q.rd_pulse;
    assign wr_data_o  = st_q.wr_data;
    assign rdy_o      = !st_q.busy;
endmodule

// File: rtl/rcmux_bus_front_chk.sv
module rcmux_bus_front_chk #(
    parameter int unsigned ROW_W  = 11,
    parameter int unsigned ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ifc_clr,
    input logic              row_cap,
    input logic              col_cap,
    input logic              busy_i,
    input logic [ADDR_W-1:0] arr_addr_o,
    input logic              wr_pulse_o,
    input logic              rd_pulse_o,
    input logic              rdy_o
);
    assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse_o |=> !wr_pulse_o);

    assert_rd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse_o |=> !rd_pulse_o);

    assert_busy_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !rdy_o);

    assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> rdy_o);

    assert_ifc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ifc_clr |=> (arr_addr_o == '0) && !wr_pulse_o && !rd_pulse_o);

    assert_row_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !row_cap && !ifc_clr |=> $stable(arr_addr_o[ROW_W-1:0]));

    assert_col_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !col_cap && !ifc_clr |=> $stable(arr_addr_o[ADDR_W-1:ROW_W]));
endmodule

bind rcmux_bus_front rcmux_bus_front_chk #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ifc_clr(ifc_clr),
    .row_cap(row_cap), .col_cap(col_cap), .busy_i(busy_i),
    .arr_addr_o(arr_addr_o), .wr_pulse_o(wr_pulse_o),
    .rd_pulse_o(rd_pulse_o), .rdy_o(rdy_o)
);

// File: tb/rcmux_bus_front_tb.sv
module rcmux_bus_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ifc_rst_n = 1'b1;
    logic [10:0] maddr = '0;
    logic        rcsel = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [7:0]  rd_byte = '0;
    logic        busy = 1'b0;
    logic [7:0]  tb_dq = '0;
    logic        tb_dq_en = 1'b0;
    wire  [7:0]  dq_w;
    logic [18:0] arr_addr;
    logic        wr_pulse, rd_pulse, rdy;
    logic [7:0]  wr_data;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 0;

    // expected item: {is_write, addr[18:0], data[7:0]}
    logic [27:0] exp_q [$];

    assign dq_w = tb_dq_en ? tb_dq : 8'hzz;

    always #4 clk = ~clk;

    rcmux_bus_front dut_i (
        .clk(clk), .rst_n(rst_n), .ifc_rst_n_i(ifc_rst_n),
        .maddr_i(maddr), .rcsel_i(rcsel), .we_n_i(we_n), .oe_n_i(oe_n),
        .dq_io(dq_w), .rd_byte_i(rd_byte), .busy_i(busy),
        .arr_addr_o(arr_addr), .wr_pulse_o(wr_pulse), .wr_data_o(wr_data),
        .rd_pulse_o(rd_pulse), .rdy_o(rdy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected transactions when pulses appear
    always @(negedge clk) begin
        if (rst_n && (wr_pulse || rd_pulse)) begin
            logic [27:0] e;
            pulses++;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R3/R4/R7 unexpected pulse actual=wr%0d_rd%0d expected=none", wr_pulse, rd_pulse);
            end else begin
                e = exp_q.pop_front();
                if (e[27] !== wr_pulse || e[27] === rd_pulse || e[26:8] !== arr_addr
                    || (e[27] && e[7:0] !== wr_data)) begin
                    failures++;
                    $display("FAIL R3/R4 txn actual=%b_%h_%h expected=%b_%h_%h",
                             wr_pulse, arr_addr, wr_data, e[27], e[26:8], e[7:0]);
                end
            end
        end
    end

    task automatic set_addr(input logic [10:0] row, input logic [10:0] col);
        maddr = row; idle(2);
        rcsel = 1'b0; idle(5);
        maddr = col; idle(2);
        rcsel = 1'b1; idle(5);
    endtask

    task automatic bus_write(input logic [7:0] d);
        tb_dq = d; tb_dq_en = 1'b1;
        we_n = 1'b0; idle(4);
        exp_q.push_back({1'b1, arr_addr, d});
        we_n = 1'b1; idle(4);
        tb_dq_en = 1'b0; idle(2);
    endtask

    task automatic bus_read(input logic [7:0] b);
        rd_byte = b;
        exp_q.push_back({1'b0, arr_addr, 8'h00});
        oe_n = 1'b0; idle(5);
        check("R5 read drive", {24'h0, dq_w}, {24'h0, b});
        oe_n = 1'b1; idle(4);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(4);
        check("R8 addr", {13'h0, arr_addr}, 32'h0);
        check("R8 pulses", {30'h0, wr_pulse, rd_pulse}, 32'h0);
        check("R8 rdy", {31'h0, rdy}, 32'h1);

        // R1 row on fall, R2 column on rise (upper bits 10..8 ignored)
        maddr = 11'h5A3; idle(2);
        rcsel = 1'b0; idle(5);
        check("R1 row", {13'h0, arr_addr}, {13'h0, 8'h00, 11'h5A3});
        maddr = 11'h7C6; idle(2);
        rcsel = 1'b1; idle(5);
        check("R2 col", {13'h0, arr_addr}, {13'h0, 8'hC6, 11'h5A3});

        // R9 address input changes without select edge
        maddr = 11'h0FF; idle(6);
        check("R9 hold", {13'h0, arr_addr}, {13'h0, 8'hC6, 11'h5A3});

        // R3 writes with several patterns
        bus_write(8'hA5);
        bus_write(8'h00);
        set_addr(11'h7FF, 11'h7FF);
        check("R2 all ones", {13'h0, arr_addr}, {13'h0, 19'h7FFFF});
        bus_write(8'hFF);
        bus_write(8'h3C);

        // R4 reads, R5 drive
        bus_read(8'h20);
        set_addr(11'h001, 11'h080);
        check("R1 new row", {13'h0, arr_addr}, {13'h0, 8'h80, 11'h001});
        bus_read(8'h96);

        // R4/R5 oe falling while we low: no read pulse, bus released
        tb_dq = 8'h5E; tb_dq_en = 1'b1;
        we_n = 1'b0; idle(4);
        oe_n = 1'b0; idle(5);
        oe_n = 1'b1; idle(4);
        exp_q.push_back({1'b1, arr_addr, 8'h5E});
        we_n = 1'b1; idle(4);
        tb_dq_en = 1'b0; idle(2);

        // R6 ready/busy
        busy = 1'b1; idle(2);
        check("R6 busy", {31'h0, rdy}, 32'h0);
        busy = 1'b0; idle(2);
        check("R6 ready", {31'h0, rdy}, 32'h1);

        // R7 interface reset
        begin
            int p0;
            p0 = pulses;
            ifc_rst_n = 1'b0; idle(5);
            check("R7 clear", {13'h0, arr_addr}, 32'h0);
            tb_dq = 8'h11; tb_dq_en = 1'b1;
            we_n = 1'b0; idle(4); we_n = 1'b1; idle(4);
            tb_dq_en = 1'b0;
            oe_n = 1'b0; idle(4); oe_n = 1'b1; idle(4);
            rcsel = 1'b0; maddr = 11'h123; idle(5); rcsel = 1'b1; idle(5);
            check("R7 no pulse", pulses, p0);
            check("R7 addr held", {13'h0, arr_addr}, 32'h0);
            ifc_rst_n = 1'b1; idle(5);
        end

        set_addr(11'h2AA, 11'h055);
        bus_write(8'h81);

        idle(4);
        check("R3/R4 queue drained", exp_q.size(), 0);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule